// File: doc/BRIEF.md
# Half-to-Single Float Widening Converter

This block widens a 16-bit half-precision floating-point bit pattern into the 32-bit single-precision bit pattern that holds exactly the same value. Every half value can be represented exactly in single precision, so there is no rounding. The block also raises no exception flags and does no arithmetic. All work is done with integer bit logic. Zeros, normals, subnormals and the all-ones exponent each take their own path. Subnormal inputs are renormalised with a leading-zero count, so the result is always a normal single.

A per-word mode input chooses how the all-ones half exponent (31) is read. In standard IEEE mode it encodes infinity or NaN. In alternative mode it is an ordinary finite exponent, and that format has no infinity or NaN. The conversion is combinational and is captured in one output register. A valid strobe travels alongside the data with one cycle of latency.

Top module: `half_widen_conv`

## Requirements
- R1: The input sign (bit 15) appears unchanged at output bit 31 for every input and either mode.
- R2: A normal input (exponent field in bits 14..10 between 1 and 30) produces output exponent (bits 30..23) equal to the input exponent plus 112. The 10 input mantissa bits (9..0) land in output bits 22..13.
- R3: Output bits 12..0 are always zero.
- R4: A subnormal input (exponent 0, mantissa nonzero) produces a normal single. Let p be the position of the mantissa's leading one. The output exponent is 103+p, and the mantissa bits below that leading one are placed from output bit 22 downward.
- R5: An input whose bits 14..0 are all zero produces an output whose bits 30..0 are zero, with the sign kept.
- R6: With alt_mode=0, input exponent 31 produces output exponent 0xFF with the 10 input mantissa bits in output bits 22..13. Infinity stays infinity and NaN keeps its payload.
- R7: With alt_mode=1, input exponent 31 produces output exponent 0x8F as a finite value, and no output ever has exponent 0xFF.
- R8: out_valid is in_valid delayed by exactly one clock, and the data for a word appears in that same cycle.
- R9: A synchronous active-low reset clears out_valid and out_single to zero.
- R10: While in_valid is low, out_single holds its previous value, whatever in_half and alt_mode do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word strobe |
| in_half | input | 16 | Half-precision bit pattern |
| alt_mode | input | 1 | 1 = all-ones exponent is finite; 0 = IEEE infinity/NaN |
| out_valid | output | 1 | Output word strobe, one cycle after in_valid |
| out_single | output | 32 | Single-precision bit pattern |

## Verification
The assertions assume that in_valid, alt_mode and in_half are known values at each rising edge once reset is released. They also assume the mode is sampled together with the word it applies to. They make no assumption about which mode or bit pattern comes next, so alt_mode may change from one word to the next. The stimulus drives every input on the falling edge and never leaves one undriven. It sweeps all 65536 patterns back to back in each mode, then idles the strobe while changing the data, so the hold and latency properties see both streaming and gapped traffic.

// File: rtl/hcvt_pkg.sv
// Package: shared format widths, biases and input class encoding for the
// half-to-single widening converter. Assumes the wide format has more
// exponent and mantissa bits than the narrow one.
package hcvt_pkg;
    localparam int HEXP_W    = 5;
    localparam int HMAN_W    = 10;
    localparam int SEXP_W    = 8;
    localparam int SMAN_W    = 23;
    localparam int HALF_W    = 1 + HEXP_W + HMAN_W;
    localparam int SGL_W     = 1 + SEXP_W + SMAN_W;
    localparam int HBIAS     = (1 << (HEXP_W - 1)) - 1;
    localparam int SBIAS     = (1 << (SEXP_W - 1)) - 1;
    localparam int BIAS_DIFF = SBIAS - HBIAS;
    localparam int PAD_W     = SMAN_W - HMAN_W;
    localparam int SHIFT_W   = $clog2(HMAN_W + 2);

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_SUB  = 2'd1,
        CLS_NORM = 2'd2,
        CLS_TOP  = 2'd3
    } half_cls_e;
endpackage

// File: rtl/hcvt_classify.sv
// Module: splits a half pattern into sign, exponent and mantissa and sorts it
// into zero, subnormal, normal or all-ones-exponent. Purely combinational.
module hcvt_classify
    import hcvt_pkg::*;
(
    input  logic [HALF_W-1:0] half_i,
    output logic              sign_o,
    output logic [HEXP_W-1:0] exp_o,
    output logic [HMAN_W-1:0] man_o,
    output half_cls_e         cls_o
);
    assign sign_o = half_i[HALF_W-1];
    assign exp_o  = half_i[HALF_W-2 -: HEXP_W];
    assign man_o  = half_i[HMAN_W-1:0];

    // Class decision from the exponent field and mantissa
    always_comb begin
        if (exp_o == '0)
            cls_o = (man_o == '0) ? CLS_ZERO : CLS_SUB;
        else if (exp_o == '1)
            cls_o = CLS_TOP;
        else
            cls_o = CLS_NORM;
    end
endmodule

// File: rtl/hcvt_renorm.sv
// Module: renormalises a subnormal mantissa. Counts leading zeros and shifts
// the leading one out past the top, returning the shift used (leading zeros
// plus one). Assumes a nonzero mantissa when its outputs are used.
module hcvt_renorm
    import hcvt_pkg::*;
#(
    parameter int MW = HMAN_W,
    parameter int SW = SHIFT_W
) (
    input  logic [MW-1:0] man_i,
    output logic [SW-1:0] shift_o,
    output logic [MW-1:0] man_o
);
    logic [SW-1:0] lz;

    // Leading-zero count: ascending scan, highest set bit wins
    always_comb begin
        lz = SW'(MW);
        for (int i = 0; i < MW; i++) begin
            if (man_i[i]) lz = SW'(MW - 1 - i);
        end
    end

    assign shift_o = lz + SW'(1);
    assign man_o   = man_i << shift_o;
endmodule

// File: rtl/hcvt_pack.sv
// Module: assembles the single-precision pattern from the classified half
// fields, the renormalised subnormal mantissa and the mode. Combinational.
module hcvt_pack
    import hcvt_pkg::*;
(
    input  logic               sign_i,
    input  logic [HEXP_W-1:0]  exp_i,
    input  logic [HMAN_W-1:0]  man_i,
    input  half_cls_e          cls_i,
    input  logic               alt_i,
    input  logic [SHIFT_W-1:0] shift_i,
    input  logic [HMAN_W-1:0]  norm_man_i,
    output logic [SGL_W-1:0]   single_o
);
    logic [SEXP_W-1:0] exp_reb;
    logic [SEXP_W-1:0] exp_sub;
    logic [SEXP_W-1:0] s_exp;
    logic [HMAN_W-1:0] s_man;

    assign exp_reb = SEXP_W'(exp_i) + SEXP_W'(BIAS_DIFF);
    assign exp_sub = SEXP_W'(BIAS_DIFF + 1) - SEXP_W'(shift_i);

    // Exponent and mantissa selection per input class and mode
    always_comb begin
        unique case (cls_i)
            CLS_ZERO: begin s_exp = '0;      s_man = '0;         end
            CLS_SUB:  begin s_exp = exp_sub; s_man = norm_man_i; end
            CLS_TOP:  begin s_exp = alt_i ? exp_reb : '1; s_man = man_i; end
            default:  begin s_exp = exp_reb; s_man = man_i;      end
        endcase
    end

    assign single_o = {sign_i, s_exp, s_man, {PAD_W{1'b0}}};
endmodule

// File: rtl/half_widen_conv.sv
// Module: top of the half-to-single widening converter. Converts the input
// word combinationally and registers result and strobe, one cycle latency.
// Assumes inputs are known at every rising edge after reset.
module half_widen_conv
    import hcvt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [HALF_W-1:0] in_half,
    input  logic              alt_mode,
    output logic              out_valid,
    output logic [SGL_W-1:0]  out_single
);
    logic               f_sign;
    logic [HEXP_W-1:0]  f_exp;
    logic [HMAN_W-1:0]  f_man;
    half_cls_e          f_cls;
    logic [SHIFT_W-1:0] r_shift;
    logic [HMAN_W-1:0]  r_man;
    logic [SGL_W-1:0]   conv;

    hcvt_classify u_cls (
        .half_i (in_half),
        .sign_o (f_sign),
        .exp_o  (f_exp),
        .man_o  (f_man),
        .cls_o  (f_cls)
    );

    hcvt_renorm #(.MW(HMAN_W), .SW(SHIFT_W)) u_ren (
        .man_i   (f_man),
        .shift_o (r_shift),
        .man_o   (r_man)
    );

    hcvt_pack u_pack (
        .sign_i     (f_sign),
        .exp_i      (f_exp),
        .man_i      (f_man),
        .cls_i      (f_cls),
        .alt_i      (alt_mode),
        .shift_i    (r_shift),
        .norm_man_i (r_man),
        .single_o   (conv)
    );

    // Output stage: strobe follows input, data loads only on a valid word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_single <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_single <= conv;
        end
    end

    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_single[SGL_W-1] == $past(in_half[HALF_W-1])); // R1
    AST_LOW_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_single[PAD_W-1:0] == '0); // R3
    AST_ZERO_KEEPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_half[HALF_W-2:0] == '0) |=> out_single[SGL_W-2:0] == '0); // R5
    AST_IEEE_TOP_EXP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !alt_mode && in_half[HALF_W-2 -: HEXP_W] == '1)
        |=> out_single[SGL_W-2 -: SEXP_W] == '1); // R6
    AST_ALT_NEVER_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && alt_mode) |=> out_single[SGL_W-2 -: SEXP_W] != '1); // R7
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_single)); // R10
endmodule

// File: tb/test_half_widen_conv.sv
module test_half_widen_conv;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] in_half;
    logic        alt_mode;
    logic        out_valid;
    logic [31:0] out_single;
    int          n_checks = 0;
    int          n_fails  = 0;
    bit          done     = 0;

    always #10 clk = ~clk;

    half_widen_conv i_half_widen_conv (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_half    (in_half),
        .alt_mode   (alt_mode),
        .out_valid  (out_valid),
        .out_single (out_single)
    );

    function automatic real pow2(input int n);
        real r = 1.0;
        if (n >= 0) for (int k = 0; k < n; k++) r = r * 2.0;
        else        for (int k = 0; k < -n; k++) r = r / 2.0;
        return r;
    endfunction

    // Reference: value computed as a real, then re-encoded from double bits
    function automatic logic [31:0] ref_model(input logic [15:0] h, input logic alt);
        int e = int'(h[14:10]);
        int m = int'(h[9:0]);
        real v;
        logic [63:0] d;
        logic [10:0] de;
        if (e == 31 && !alt) return {h[15], 8'hFF, h[9:0], 13'b0};
        if (e == 0 && m == 0) return {h[15], 31'b0};
        if (e == 0) v = real'(m) * pow2(-24);
        else        v = real'(1024 + m) * pow2(e - 25);
        d  = $realtobits(v);
        de = d[62:52] - 11'd896;
        return {h[15], de[7:0], d[51:29]};
    endfunction

    function automatic string tag_of(input logic [15:0] h, input logic alt);
        if (h[14:0] == 15'd0) return "R5";
        if (h[14:10] == 5'd0) return "R4";
        if (h[14:10] == 5'd31) return alt ? "R7" : "R6";
        return "R2";
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // R9: state straight out of reset
    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b1; in_half = 16'h3C00; alt_mode = 1'b0;
        repeat (3) @(negedge clk);
        check({31'b0, out_valid}, 32'd0, "R9 out_valid in reset");
        check(out_single, 32'd0, "R9 out_single in reset");
        in_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    // Single word, checked one cycle later
    task automatic one(input logic [15:0] h, input logic alt, input logic [31:0] exp, input string tag);
        @(negedge clk);
        in_half = h; alt_mode = alt; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_single, exp, tag);
        check({31'b0, out_valid}, 32'd1, "R8 strobe with word");
    endtask

    task automatic t_corners();
        one(16'h3C00, 1'b0, 32'h3F800000, "R2 one");
        one(16'hC000, 1'b0, 32'hC0000000, "R1 minus two");
        one(16'h0001, 1'b0, 32'h33800000, "R4 smallest subnormal");
        one(16'h03FF, 1'b0, 32'h387FC000, "R4 largest subnormal");
        one(16'h8000, 1'b0, 32'h80000000, "R5 negative zero");
        one(16'h7C00, 1'b0, 32'h7F800000, "R6 infinity");
        one(16'h7E01, 1'b0, 32'h7FC02000, "R6 NaN payload");
        one(16'h7C00, 1'b1, 32'h47800000, "R7 alt top exponent");
        one(16'hFFFF, 1'b1, 32'hC7FFE000, "R7 alt largest negative");
    endtask

    // R10 and R8: idle strobe with changing data keeps output
    task automatic t_hold();
        one(16'h4248, 1'b0, 32'h40490000, "R2 pi-ish");
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            in_half = 16'h7C00 ^ 16'(k); alt_mode = k[0];
            check(out_single, 32'h40490000, "R10 hold while idle");
            check({31'b0, out_valid}, 32'd0, "R8 idle strobe");
        end
    endtask

    // R9: reset in the middle of traffic
    task automatic t_reset_mid();
        one(16'h3C00, 1'b0, 32'h3F800000, "R2 before reset");
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        check({31'b0, out_valid}, 32'd0, "R9 mid-run out_valid");
        check(out_single, 32'd0, "R9 mid-run out_single");
        rst_n = 1'b1; in_valid = 1'b0;
    endtask

    // Full sweep streamed back to back; covers R1 R3 and every class
    task automatic t_sweep(input logic alt);
        logic [31:0] exp_q = '0;
        string       tag_q = "";
        bit          have  = 0;
        for (int v = 0; v < 65536; v++) begin
            @(negedge clk);
            if (have) begin
                check(out_single, exp_q, tag_q);
                if (out_valid !== 1'b1) check(32'd0, 32'd1, "R8 sweep strobe");
            end
            in_half = 16'(v); alt_mode = alt; in_valid = 1'b1;
            exp_q = ref_model(16'(v), alt);
            tag_q = tag_of(16'(v), alt);
            have = 1;
        end
        @(negedge clk);
        check(out_single, exp_q, tag_q);
        in_valid = 1'b0;
        @(negedge clk);
        check({31'b0, out_valid}, 32'd0, "R8 strobe drops");
    endtask

    initial begin
        t_reset();
        t_corners();
        t_hold();
        t_reset_mid();
        t_sweep(1'b0);
        t_sweep(1'b1);
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule